// File: doc/BRIEF.md
# Buffered Transmit Sequencer With Auto-Start

This block drives the transmit side of a packet radio's digital back end. A host write path delivers bytes one strobe at a time, and the block holds them in a small FIFO. When transmit mode is requested, the block first sits in a warm-up phase until the synthesizer reports lock. It then becomes live. Once it is live and the FIFO holds at least the start count supplied with the most recent write, it begins to serialize the queued bytes, most significant bit first. Each bit goes out either as NRZ or Manchester-coded, at one of four selectable rates.

A pending-byte counter covers both the bytes in the FIFO and the byte in the shifter. The host can read it at any time, and a one-cycle interrupt fires when the counter reaches a selectable level. A transparent mode disables the FIFO and forwards a direct data input to the line. A configuration write strobe flushes the queue, the counter and the sticky error flags, and aborts any byte in flight. Overflow (a write into a full FIFO) and underrun (nothing to send while serialization is running) are each reported by a sticky flag.

Top module: `txseq_top`

## Requirements
- R1: After reset, `phase` is 0, `tx_bit`, `tx_busy`, `irq`, `ovf_flag` and `udr_flag` are 0, and `pend_count` is 0.
- R2: `phase` encodes 0 = idle, 1 = warm-up, 2 = live. Raising `tx_en` moves idle to warm-up. Warm-up moves to live only in a cycle where `pll_lock` is high. Dropping `tx_en` returns to idle and empties the queue.
- R3: A byte write (`wr_valid`) is accepted in warm-up or live and raises `pend_count` by one. In idle the write is ignored and `pend_count` stays unchanged.
- R4: Serialization starts only when `phase` is live and the FIFO holds at least N bytes. N is `wr_start_n` from the latest accepted write, and values above DEPTH are treated as DEPTH.
- R5: Bytes leave most significant bit first. Each bit lasts two half-bit periods of DIV_BASE << `baud_sel` clocks, and `tx_busy` is high exactly while a byte is on the line.
- R6: With `nrz_mode` low, each bit is Manchester-coded: the first half-bit carries the inverted data value and the second half carries the true value. With `nrz_mode` high, both halves carry the data value.
- R7: `pend_count` rises by one per accepted byte and falls by one when a byte's last half-bit ends. It always equals the FIFO occupancy plus one while a byte is in the shifter.
- R8: `irq` pulses for one cycle when `pend_count` changes to `irq_sel` × DEPTH/4 (0, 4, 8 or 12 for DEPTH 16). A flush never raises it.
- R9: With `transparent` high, writes are ignored, `tx_busy` stays low, and in the live phase `tx_bit` equals `direct_bit` delayed by one clock. Outside the live phase `tx_bit` is 0.
- R10: A `cfg_wr` pulse empties the FIFO, clears `pend_count`, `ovf_flag` and `udr_flag`, and aborts the byte on the line.
- R11: A write while the FIFO is full is dropped and sets the sticky `ovf_flag`.
- R12: While serialization runs with an empty FIFO and no byte on the line, `tx_bit` is held low and the sticky `udr_flag` is set.
- R13: When the next byte is already queued, it follows the previous byte with no idle gap, and `tx_busy` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit mode request |
| pll_lock | input | 1 | Synthesizer lock indication |
| cfg_wr | input | 1 | Configuration write strobe (flush) |
| baud_sel | input | 2 | Bit-rate select |
| nrz_mode | input | 1 | 1 = NRZ, 0 = Manchester |
| transparent | input | 1 | Bypass the FIFO, forward `direct_bit` |
| irq_sel | input | 2 | Interrupt level select |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_start_n | input | 5 | Start count N carried with the write |
| direct_bit | input | 1 | Transparent-mode data input |
| tx_bit | output | 1 | Line bit to the modulator |
| tx_busy | output | 1 | A byte is on the line |
| phase | output | 2 | 0 idle, 1 warm-up, 2 live |
| pend_count | output | 5 | Bytes still to transmit |
| irq | output | 1 | Count-level interrupt pulse |
| ovf_flag | output | 1 | Sticky overflow |
| udr_flag | output | 1 | Sticky underrun |

## Verification
The bench keeps the default DEPTH of 16 so that the full-FIFO overflow boundary and all four interrupt levels stay within reach. It lowers DIV_BASE to 2, which gives half-bit periods of 2, 4, 8 and 16 clocks. With these short periods, multi-byte Manchester streams, back-to-back continuity and a slow-rate byte-length measurement all fit in a short run, while the two-clock half-bit still has a clear middle to sample.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WARM = 2'd1,
    PH_LIVE = 2'd2
  } phase_t;
endpackage

// File: rtl/txseq_fifo.sv
module txseq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/txseq_serializer.sv
module txseq_serializer #(
  parameter int DW       = 8,
  parameter int DIV_BASE = 4,
  localparam int HB_W    = $clog2(DIV_BASE * 8) + 1,
  localparam int BIT_W   = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          enable,
  input  logic [1:0]    baud_sel,
  input  logic          nrz,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          pop,
  output logic          byte_done,
  output logic          ser_bit,
  output logic          ser_busy,
  output logic          starve
);
  logic [HB_W-1:0]  hcnt, half_len;
  logic [BIT_W-1:0] bidx;
  logic [DW-1:0]    sh;
  logic             half, busy, half_end, last;

  assign half_len  = HB_W'(DIV_BASE) << baud_sel;
  assign half_end  = busy && (hcnt >= half_len - HB_W'(1));
  assign last      = half_end && half && (bidx == BIT_W'(DW - 1));
  assign byte_done = last;
  assign pop       = enable && !flush && !fifo_empty && (!busy || last);
  assign starve    = enable && !busy && fifo_empty;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy <= 1'b0;
      half <= 1'b0;
      hcnt <= '0;
      bidx <= '0;
      sh   <= '0;
    end else if (pop) begin
      sh   <= fifo_data;
      busy <= 1'b1;
      half <= 1'b0;
      hcnt <= '0;
      bidx <= '0;
    end else if (last) begin
      busy <= 1'b0;
      half <= 1'b0;
      hcnt <= '0;
    end else if (half_end) begin
      hcnt <= '0;
      half <= ~half;
      if (half) begin
        bidx <= bidx + BIT_W'(1);
        sh   <= sh << 1;
      end
    end else if (busy) begin
      hcnt <= hcnt + HB_W'(1);
    end
  end

  // Manchester: inverted value first, true value second
  assign ser_bit  = busy && (nrz ? sh[DW-1] : (half ? sh[DW-1] : ~sh[DW-1]));
  assign ser_busy = busy;
endmodule

// File: rtl/txseq_top.sv
module txseq_top #(
  parameter int DEPTH    = 16,
  parameter int DIV_BASE = 4,
  localparam int DW      = 8,
  localparam int THR_W   = $clog2(DEPTH + 1),
  localparam int CNT_W   = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             pll_lock,
  input  logic             cfg_wr,
  input  logic [1:0]       baud_sel,
  input  logic             nrz_mode,
  input  logic             transparent,
  input  logic [1:0]       irq_sel,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  input  logic [THR_W-1:0] wr_start_n,
  input  logic             direct_bit,
  output logic             tx_bit,
  output logic             tx_busy,
  output logic [1:0]       phase,
  output logic [CNT_W-1:0] pend_count,
  output logic             irq,
  output logic             ovf_flag,
  output logic             udr_flag
);
  import txseq_pkg::*;

  phase_t           ph;
  logic             flush, wr_ok, push, running;
  logic [THR_W-1:0] n_reg, fifo_cnt;
  logic [DW-1:0]    fifo_q;
  logic             fifo_full, fifo_empty;
  logic             pop, byte_done, ser_bit, ser_busy, starve;
  logic [CNT_W-1:0] pend_nxt, irq_lvl;

  assign flush = (ph == PH_IDLE) || cfg_wr;
  assign wr_ok = wr_valid && (ph != PH_IDLE) && !transparent && !cfg_wr;
  assign push  = wr_ok && !fifo_full;

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else begin
      unique case (ph)
        PH_IDLE: if (tx_en) ph <= PH_WARM;
        PH_WARM: if (!tx_en) ph <= PH_IDLE;
                 else if (pll_lock) ph <= PH_LIVE;
        PH_LIVE: if (!tx_en) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) n_reg <= THR_W'(1);
    else if (wr_ok)
      n_reg <= (wr_start_n > THR_W'(DEPTH)) ? THR_W'(DEPTH) : wr_start_n;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) running <= 1'b0;
    else if (ph == PH_LIVE && !transparent && fifo_cnt >= n_reg) running <= 1'b1;
  end

  txseq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .wdata(wr_data),
    .pop(pop), .rdata(fifo_q), .count(fifo_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  txseq_serializer #(.DW(DW), .DIV_BASE(DIV_BASE)) u_ser (
    .clk(clk), .rst(rst), .flush(flush), .enable(running && !transparent),
    .baud_sel(baud_sel), .nrz(nrz_mode), .fifo_empty(fifo_empty), .fifo_data(fifo_q),
    .pop(pop), .byte_done(byte_done), .ser_bit(ser_bit), .ser_busy(ser_busy),
    .starve(starve)
  );

  assign pend_nxt = flush ? '0 : pend_count + CNT_W'(push) - CNT_W'(byte_done);
  assign irq_lvl  = CNT_W'(irq_sel) * CNT_W'(DEPTH / 4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_count <= '0;
      irq        <= 1'b0;
      ovf_flag   <= 1'b0;
      udr_flag   <= 1'b0;
      tx_bit     <= 1'b0;
      tx_busy    <= 1'b0;
    end else begin
      pend_count <= pend_nxt;
      irq        <= !flush && (pend_nxt != pend_count) && (pend_nxt == irq_lvl);
      if (cfg_wr) begin
        ovf_flag <= 1'b0;
        udr_flag <= 1'b0;
      end else begin
        if (wr_ok && fifo_full) ovf_flag <= 1'b1;
        if (starve && !flush)   udr_flag <= 1'b1;
      end
      tx_bit  <= transparent ? ((ph == PH_LIVE) && direct_bit) : ser_bit;
      tx_busy <= !transparent && ser_busy;
    end
  end

  assign phase = ph;
endmodule

// File: rtl/txseq_checker.sv
module txseq_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int THR_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       phase,
  input logic             pll_lock,
  input logic             cfg_wr,
  input logic             transparent,
  input logic             direct_bit,
  input logic             tx_bit,
  input logic             tx_busy,
  input logic             irq,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] pend_count,
  input logic [THR_W-1:0] fifo_cnt,
  input logic             ser_busy,
  input logic             pop,
  input logic             fifo_empty
);
  assert_lock_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd1 && !pll_lock) |=> (phase != 2'd2));

  assert_count_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    32'(pend_count) == 32'(fifo_cnt) + 32'(ser_busy));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    32'(pend_count) <= DEPTH + 1);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_transparent_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (transparent && phase == 2'd2) |=> (tx_bit == $past(direct_bit)));

  assert_no_overflow_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !cfg_wr) |=> ovf_flag);

  assert_no_pop_empty_R12: assert property (@(posedge clk) disable iff (rst)
    pop |-> !fifo_empty);

  assert_idle_low_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(transparent) && !tx_busy) |-> !tx_bit);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && $past(phase) == 2'd0) |=> !tx_busy);
endmodule

bind txseq_top txseq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .pll_lock(pll_lock), .cfg_wr(cfg_wr),
  .transparent(transparent), .direct_bit(direct_bit), .tx_bit(tx_bit),
  .tx_busy(tx_busy), .irq(irq), .ovf_flag(ovf_flag), .pend_count(pend_count),
  .fifo_cnt(fifo_cnt), .ser_busy(ser_busy), .pop(pop), .fifo_empty(fifo_empty)
);

// File: tb/tb_txseq_top.sv
`timescale 1ns/1ps
module tb_txseq_top;
  localparam int DEPTH = 16;
  localparam int DIVB  = 2;

  logic clk = 0, rst = 1;
  logic tx_en = 0, pll_lock = 0, cfg_wr = 0, nrz_mode = 1, transparent = 0;
  logic wr_valid = 0, direct_bit = 0;
  logic [1:0] baud_sel = 0, irq_sel = 0;
  logic [7:0] wr_data = 0;
  logic [4:0] wr_start_n = 1;
  logic tx_bit, tx_busy, irq, ovf_flag, udr_flag;
  logic [1:0] phase;
  logic [4:0] pend_count;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;

  always #5 clk = ~clk;

  txseq_top #(.DEPTH(DEPTH), .DIV_BASE(DIVB)) dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .pll_lock(pll_lock), .cfg_wr(cfg_wr),
    .baud_sel(baud_sel), .nrz_mode(nrz_mode), .transparent(transparent),
    .irq_sel(irq_sel), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_start_n(wr_start_n), .direct_bit(direct_bit), .tx_bit(tx_bit),
    .tx_busy(tx_busy), .phase(phase), .pend_count(pend_count), .irq(irq),
    .ovf_flag(ovf_flag), .udr_flag(udr_flag)
  );

  always @(negedge clk) if (!rst && irq) irq_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic [4:0] n);
    wr_data = d; wr_start_n = n; wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
    @(negedge clk);
  endtask

  task automatic begin_tx(input logic lock);
    tx_en = 0;
    repeat (3) @(negedge clk);
    pll_lock = lock; tx_en = 1;
    repeat (3) @(negedge clk);
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    @(negedge clk);
  endtask

  task automatic wait_busy(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (tx_busy) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  // call at the first negedge where tx_busy is high
  task automatic rx_bytes(input int n, input bit manch, input int hb,
                          output logic [15:0] got, output int gaps, output int cerr);
    got = 0; gaps = 0; cerr = 0;
    repeat (hb / 2) @(negedge clk);
    for (int b = 0; b < n * 8; b++) begin
      logic a;
      a = tx_bit;
      if (!tx_busy) gaps++;
      repeat (hb) @(negedge clk);
      if (!tx_busy) gaps++;
      if (manch) begin
        if (a == tx_bit) cerr++;
        got = {got[14:0], tx_bit};
      end else begin
        if (a != tx_bit) cerr++;
        got = {got[14:0], a};
      end
      if (b != n * 8 - 1) repeat (hb) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 tx_bit", tx_bit, 0);
    chk("R1 busy", tx_busy, 0);
    chk("R1 count", pend_count, 0);
    chk("R1 flags", {irq, ovf_flag, udr_flag}, 0);
  endtask

  task automatic t_idle_drop();
    tx_en = 0;
    repeat (2) @(negedge clk);
    wr_byte(8'h11, 1);
    chk("R3 idle write ignored", pend_count, 0);
  endtask

  task automatic t_warmup_start();
    logic [15:0] got; int gaps, cerr; bit seen;
    nrz_mode = 1; baud_sel = 0; irq_sel = 0;
    begin_tx(0);
    chk("R2 warm-up phase", phase, 1);
    wr_byte(8'hA5, 1);
    chk("R3 warm-up write counted", pend_count, 1);
    repeat (10) @(negedge clk);
    chk("R4 no start before lock", tx_busy, 0);
    pll_lock = 1;
    @(negedge clk);
    chk("R2 live after lock", phase, 2);
    wait_busy(seen);
    chk("R4 start after lock", seen, 1);
    rx_bytes(1, 0, 2, got, gaps, cerr);
    chk("R5 NRZ msb-first byte", got[7:0], 8'hA5);
    chk("R6 NRZ halves equal", cerr, 0);
    repeat (6) @(negedge clk);
    chk("R7 count drained", pend_count, 0);
    chk("R12 underrun flag", udr_flag, 1);
    chk("R12 line low", tx_bit, 0);
  endtask

  task automatic t_thresh_manch();
    logic [15:0] got; int gaps, cerr; bit seen;
    nrz_mode = 0; baud_sel = 0; irq_sel = 0;
    begin_tx(1);
    irq_cnt = 0;
    wr_byte(8'h3C, 2);
    repeat (20) @(negedge clk);
    chk("R4 below start count idle", tx_busy, 0);
    chk("R7 one pending", pend_count, 1);
    wr_byte(8'hC1, 2);
    wait_busy(seen);
    chk("R4 start at count", seen, 1);
    rx_bytes(2, 1, 2, got, gaps, cerr);
    chk("R6 Manchester data", got, 16'h3CC1);
    chk("R6 Manchester coding", cerr, 0);
    chk("R13 no gap", gaps, 0);
    repeat (6) @(negedge clk);
    chk("R8 irq at zero level", irq_cnt, 1);
  endtask

  task automatic t_baud();
    bit seen; int len;
    nrz_mode = 1; baud_sel = 2;
    begin_tx(1);
    wr_byte(8'h5A, 1);
    wait_busy(seen);
    len = 0;
    for (int i = 0; i < 400 && tx_busy; i++) begin
      len++;
      @(negedge clk);
    end
    chk("R5 byte length baud 2", len, 16 * (DIVB << 2));
    baud_sel = 0;
  endtask

  task automatic t_irq_ovf();
    begin_tx(0);
    irq_sel = 1;
    irq_cnt = 0;
    for (int i = 0; i < 5; i++) wr_byte(8'(i), 16);
    chk("R8 one irq at level 4", irq_cnt, 1);
    chk("R7 five pending", pend_count, 5);
    for (int i = 0; i < 12; i++) wr_byte(8'(i), 16);
    chk("R11 count capped", pend_count, 16);
    chk("R11 overflow flag", ovf_flag, 1);
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    @(negedge clk);
    chk("R10 count cleared", pend_count, 0);
    chk("R10 overflow cleared", ovf_flag, 0);
    chk("R8 flush no irq", irq_cnt, 1);
    irq_sel = 0;
  endtask

  task automatic t_cfg_abort();
    bit seen;
    nrz_mode = 1;
    begin_tx(1);
    wr_byte(8'hFF, 1);
    wr_byte(8'hFF, 1);
    wait_busy(seen);
    repeat (4) @(negedge clk);
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    repeat (2) @(negedge clk);
    chk("R10 byte aborted", tx_busy, 0);
    chk("R10 count after abort", pend_count, 0);
  endtask

  task automatic t_transparent();
    transparent = 1;
    begin_tx(1);
    direct_bit = 1;
    @(negedge clk);
    chk("R9 follows 1", tx_bit, 1);
    direct_bit = 0;
    @(negedge clk);
    chk("R9 follows 0", tx_bit, 0);
    direct_bit = 1;
    wr_byte(8'h77, 1);
    chk("R9 write ignored", pend_count, 0);
    chk("R9 busy low", tx_busy, 0);
    tx_en = 0;
    repeat (2) @(negedge clk);
    chk("R9 low outside live", tx_bit, 0);
    transparent = 0; direct_bit = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_idle_drop();
    t_warmup_start();
    t_thresh_manch();
    t_baud();
    t_irq_ovf();
    t_cfg_abort();
    t_transparent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule